// File: doc/BRIEF.md
# Coin-Accumulating Vending Controller

This controller collects five-cent and ten-cent coin pulses, one coin per clock cycle, and keeps a running credit toward a fixed price of fifteen cents. When the credit reaches the price, the controller raises an open signal that releases the item. Any credit at or above the price is held as exactly fifteen cents, and no change is returned. Only a synchronous reset takes the controller back to zero credit.

The credit is held in four named states: `ST_EMPTY` (0 cents, code 00), `ST_FIVE` (5 cents, code 01), `ST_TEN` (10 cents, code 10) and `ST_PAID` (15 cents, code 11). Eight transitions change the state: EMPTY→FIVE on a nickel, EMPTY→TEN on a dime, FIVE→TEN on a nickel, FIVE→PAID on a dime, TEN→PAID on either coin, and any state→EMPTY on reset. In every other case the state stays where it is: no coin, or any coin while in PAID.

The parameter `OPEN_STYLE` chooses how the open signal is built. With 0 (Moore form), open is decoded from the state register. With 1 (registered Mealy form), open is computed from the state and the coin inputs on the transition, then captured in its own flip-flop, so a glitch on an input never reaches the output. The current state is also driven out on its own port.

Top module: `coin_vend_ctrl`

## Requirements
- R1: When `rst` is high at a rising clock edge, the state becomes 00 (`ST_EMPTY`) and `vend_open` becomes 0 after that edge, whatever the coin inputs are.
- R2: `credit_state` always shows the state code: 00 for 0 cents, 01 for 5 cents, 10 for 10 cents and 11 for 15 cents.
- R3: A nickel alone (`coin_nickel`=1, `coin_dime`=0) advances the state by one step at the edge: 00→01, 01→10, 10→11.
- R4: A dime advances the state by ten cents, saturating at 11: 00→10, 01→11, 10→11.
- R5: With both coin inputs low and reset low, the state does not change at the edge.
- R6: In state 11, any coin input leaves the state at 11. Only reset leaves state 11.
- R7: When both coin inputs are high in the same cycle, the dime is counted and the nickel is ignored. For example, 00 goes to 10 (not 11) and 01 goes to 11.
- R8: With `OPEN_STYLE`=0, `vend_open` is 1 exactly while the state is 11.
- R9: With `OPEN_STYLE`=1, `vend_open` comes from a flip-flop loaded at each edge with the transition output, which is 1 when the coin step reaches 15 cents or when the state is already 11. It changes only at rising clock edges. Its per-cycle value matches the Moore form.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| coin_nickel | input | 1 | Five-cent coin pulse for this cycle |
| coin_dime | input | 1 | Ten-cent coin pulse for this cycle |
| vend_open | output | 1 | Release the item |
| credit_state | output | 2 | Current credit state code |

## Verification
The bench builds two copies of the block side by side, one with `OPEN_STYLE`=0 and one with `OPEN_STYLE`=1. Both copies receive the same coin stream and are compared against the same expected state and open values. The Moore copy shows the decode from the state. The registered Mealy copy exposes the output flip-flop. A coin pulse that rises and falls between clock edges, and a coin that arrives before an edge, show that the registered output ignores input changes until the edge. Running both copies on one stream also shows that the two forms give the same sequence at the ports.

// File: rtl/coin_vend_pkg.sv
package coin_vend_pkg;
    localparam int STATE_W = 2;

    typedef enum logic [STATE_W-1:0] {
        ST_EMPTY = 2'b00,
        ST_FIVE  = 2'b01,
        ST_TEN   = 2'b10,
        ST_PAID  = 2'b11
    } credit_t;

    localparam int STYLE_MOORE     = 0;
    localparam int STYLE_REG_MEALY = 1;
endpackage

// File: rtl/coin_vend_next.sv
module coin_vend_next
    import coin_vend_pkg::*;
(
    input  credit_t cur,
    input  logic    nickel,
    input  logic    dime,
    output credit_t nxt,
    output logic    reach_paid
);
    // Dime is examined first, so a nickel in the same cycle is dropped (R7)
    always_comb begin
        nxt        = cur;
        reach_paid = 1'b0;
        unique case (cur)
            ST_EMPTY: begin
                if (dime)        nxt = ST_TEN;
                else if (nickel) nxt = ST_FIVE;
            end
            ST_FIVE: begin
                if (dime) begin
                    nxt        = ST_PAID;
                    reach_paid = 1'b1;
                end else if (nickel) begin
                    nxt = ST_TEN;
                end
            end
            ST_TEN: begin
                if (dime || nickel) begin
                    nxt        = ST_PAID;
                    reach_paid = 1'b1;
                end
            end
            ST_PAID: begin
                nxt        = ST_PAID;   // saturates, no change returned (R6)
                reach_paid = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/coin_vend_ctrl.sv
module coin_vend_ctrl
    import coin_vend_pkg::*;
#(
    parameter int OPEN_STYLE = STYLE_MOORE
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                coin_nickel,
    input  logic                coin_dime,
    output logic                vend_open,
    output logic [STATE_W-1:0]  credit_state
);
    credit_t state_q;
    credit_t state_d;
    logic    reach_paid;

    coin_vend_next u_next (
        .cur        (state_q),
        .nickel     (coin_nickel),
        .dime       (coin_dime),
        .nxt        (state_d),
        .reach_paid (reach_paid)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_EMPTY;
        else     state_q <= state_d;
    end

    assign credit_state = state_q;

    // Output process, one variant per style
    generate
        if (OPEN_STYLE == STYLE_MOORE) begin : g_moore
            always_comb vend_open = (state_q == ST_PAID);

            // R8: a transition output of 1 always lands in the paid state
            a_r8_moore_follows: assert property (@(posedge clk) disable iff (rst)
                reach_paid |=> vend_open);
        end else begin : g_reg_mealy
            logic open_q;
            always_ff @(posedge clk) begin
                if (rst) open_q <= 1'b0;
                else     open_q <= reach_paid;
            end
            always_comb vend_open = open_q;

            // R9: separate output flop tracks the state register
            a_r9_reg_open_matches: assert property (@(posedge clk) disable iff (rst)
                vend_open == (state_q == ST_PAID));
        end
    endgenerate

    // R3: nickel alone from empty lands in five
    a_r3_nickel_step: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_EMPTY && coin_nickel && !coin_dime) |=> state_q == ST_FIVE);

    // R5: idle cycle keeps the credit
    a_r5_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!coin_nickel && !coin_dime) |=> $stable(state_q));

    // R6: the paid state is sticky until reset
    a_r6_paid_sticky: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PAID) |=> state_q == ST_PAID);

    // R7: both coins from empty count only the dime
    a_r7_dime_wins: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_EMPTY && coin_nickel && coin_dime) |=> state_q == ST_TEN);
endmodule

// File: tb/coin_vend_ctrl_test.sv
`timescale 1ns/1ps
module coin_vend_ctrl_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic nk  = 1'b0;
    logic dm  = 1'b0;
    logic       open_m, open_r;
    logic [1:0] st_m, st_r;
    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    coin_vend_ctrl #(.OPEN_STYLE(0)) uut (
        .clk(clk), .rst(rst), .coin_nickel(nk), .coin_dime(dm),
        .vend_open(open_m), .credit_state(st_m));

    coin_vend_ctrl #(.OPEN_STYLE(1)) uut_mealy (
        .clk(clk), .rst(rst), .coin_nickel(nk), .coin_dime(dm),
        .vend_open(open_r), .credit_state(st_r));

    // {rst, nickel, dime, expected state[1:0], expected open}
    localparam int NV = 24;
    localparam logic [5:0] VEC [NV] = '{
        6'b100_00_0, 6'b010_01_0, 6'b000_01_0, 6'b010_10_0,
        6'b010_11_1, 6'b010_11_1, 6'b001_11_1, 6'b100_00_0,
        6'b001_10_0, 6'b001_11_1, 6'b100_00_0, 6'b011_10_0,
        6'b100_00_0, 6'b010_01_0, 6'b001_11_1, 6'b000_11_1,
        6'b100_00_0, 6'b010_01_0, 6'b011_11_1, 6'b100_00_0,
        6'b101_00_0, 6'b001_10_0, 6'b011_11_1, 6'b100_00_0
    };

    task automatic check(input string tag, input string what,
                         input logic [1:0] act, input logic [1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic r, input logic n, input logic d);
        @(negedge clk);
        rst = r; nk = n; dm = d;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [1:0] prev;
        string tag;
        string otag;
        // Reset state (R1, R2)
        step(1, 1, 1);
        check("R1", "moore state after reset", st_m, 2'b00);
        check("R1", "mealy state after reset", st_r, 2'b00);
        check("R1", "moore open after reset", {1'b0, open_m}, 2'b00);
        check("R1", "mealy open after reset", {1'b0, open_r}, 2'b00);
        prev = 2'b00;

        for (int i = 0; i < NV; i++) begin
            logic [5:0] v;
            v = VEC[i];
            step(v[5], v[4], v[3]);
            if (v[5])                tag = "R1";
            else if (v[4] && v[3])   tag = "R7";
            else if (prev == 2'b11)  tag = "R6";
            else if (v[3])           tag = "R4";
            else if (v[4])           tag = "R3";
            else                     tag = "R5";
            check(tag, "moore state code (R2)", st_m, v[2:1]);
            check(tag, "mealy state code (R2)", st_r, v[2:1]);
            otag = "R8";
            check(otag, "moore open", {1'b0, open_m}, {1'b0, v[0]});
            otag = "R9";
            check(otag, "mealy open", {1'b0, open_r}, {1'b0, v[0]});
            prev = v[2:1];
        end

        // R9: mid-cycle dime glitch while at ten cents must not reach the output
        step(1, 0, 0);
        step(0, 0, 1);
        check("R4", "state at ten", st_r, 2'b10);
        @(negedge clk);
        dm = 1'b0;
        #0.5 dm = 1'b1;
        #0.5;
        check("R9", "mealy open during glitch", {1'b0, open_r}, 2'b00);
        #0.3 dm = 1'b0;
        @(posedge clk);
        #1;
        check("R5", "state after glitch", st_r, 2'b10);
        check("R9", "mealy open after glitch", {1'b0, open_r}, 2'b00);

        // R9: coin present before the edge does not raise open until the edge
        @(negedge clk);
        nk = 1'b1;
        #1;
        check("R9", "mealy open before edge", {1'b0, open_r}, 2'b00);
        @(posedge clk);
        #1;
        check("R9", "mealy open after edge", {1'b0, open_r}, 2'b01);
        check("R8", "moore open after edge", {1'b0, open_m}, 2'b01);

        // R1: reset leaves paid even with coins
        step(1, 1, 1);
        check("R1", "state reset from paid", st_m, 2'b00);
        check("R1", "mealy open reset from paid", {1'b0, open_r}, 2'b00);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule